// File: doc/BRIEF.md
# Asynchronous-Load Parallel-to-Serial Shift Register

This block turns an eight-bit parallel word into a serial bit stream. It has a level-sensitive load control. While the control is high, every stage is forced to the matching parallel input bit through its direct set and clear, with no clock involved. If a parallel bit changes while load stays high, its stage follows at once.

Once load is released, each rising clock edge moves the contents one stage toward the end of the chain. The serial input fills the first stage. Only the final three stages leave the block, and the last of them doubles as the serial output.

The storage is fully static. It keeps its value for as long as the clock is stopped, and it has no lower limit on clock rate. There is no separate reset: asserting load is how the contents are initialised.

Top module: `psr_shift_top`

## Requirements
- R1: The register has exactly eight stages by default (WIDTH = 8). After a load followed by seven shifts, the serial output shows parallel bit 0. After an eighth shift it shows the first serial bit shifted in.
- R2: While load_i is high, every stage equals the matching par_i bit without any clock edge. A change on par_i during load reaches the stages without a clock.
- R3: While load_i is low, each rising clk_i edge stores ser_i in stage 0 and copies stage i-1 into stage i for i from 1 to 7.
- R4: tap_o[0], tap_o[1] and tap_o[2] show stages 5, 6 and 7. ser_o equals stage 7. Stages 0 to 4 have no output.
- R5: Rising clk_i edges that occur while load_i is high change nothing. The first rising edge after load_i falls performs the first shift.
- R6: With clk_i held still and load_i low, the contents stay unchanged for any length of time.
- R7: Each stage is loaded through a direct set (par bit 1) or a direct clear (par bit 0), and the two are never active together.
- R8: par_i bit k loads stage k. Directly after a load, tap_o equals par_i[7:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge active |
| load_i | input | 1 | Asynchronous parallel load, active high, overrides the clock |
| par_i | input | WIDTH | Parallel data, bit k goes to stage k |
| ser_i | input | 1 | Serial data entering stage 0 |
| tap_o | output | TAPS | Last three stages, bit 0 = stage WIDTH-3 |
| ser_o | output | 1 | Serial data out, stage WIDTH-1 |

## Verification
The clocked shift assertions assume two things. First, load_i and par_i never change close to a rising clock edge, so releasing set or clear never competes with a capture. Second, ser_i is settled before each edge. The bench meets both by changing every input only while clk_i is low, half a period away from any rising edge. The shift checks are only enabled from the second edge after load falls, because the first edge after release has no previous shifted state to compare against.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_DEF_WIDTH = 8;
    localparam int PSR_DEF_TAPS  = 3;

    typedef enum logic [1:0] {
        DRV_HOLD  = 2'b00,
        DRV_SET   = 2'b01,
        DRV_CLEAR = 2'b10
    } drive_e;

    function automatic drive_e load_drive(input logic load, input logic bit_in);
        if (!load)  return DRV_HOLD;
        if (bit_in) return DRV_SET;
        return DRV_CLEAR;
    endfunction
endpackage

// File: rtl/psr_load_decode.sv
module psr_load_decode
    import psr_pkg::*;
#(
    parameter int WIDTH = PSR_DEF_WIDTH
) (
    input  logic             load_i,
    input  logic [WIDTH-1:0] par_i,
    output logic [WIDTH-1:0] set_o,
    output logic [WIDTH-1:0] clr_o
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        drive_e drv;
        always_comb begin
            drv      = load_drive(load_i, par_i[k]);
            set_o[k] = (drv == DRV_SET);
            clr_o[k] = (drv == DRV_CLEAR);
        end
    end
endmodule

// File: rtl/psr_stage.sv
module psr_stage (
    input  logic clk_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic d_i,
    output logic q_o
);
    logic bit_q;

    always_ff @(posedge clk_i or posedge set_i or posedge clr_i) begin
        if (clr_i)      bit_q <= 1'b0;
        else if (set_i) bit_q <= 1'b1;
        else            bit_q <= d_i;
    end

    assign q_o = bit_q;

    // R7: direct set and direct clear never overlap
    a_r7_set_clr_excl: assert property (@(posedge clk_i) !(set_i && clr_i))
        else $error("set and clear active together");

    // R2: a forced stage holds the forced value
    always @(negedge clk_i) begin
        if (set_i) a_r2_set_forces: assert (bit_q == 1'b1) else $error("set not applied");
        if (clr_i) a_r2_clr_forces: assert (bit_q == 1'b0) else $error("clear not applied");
    end
endmodule

// File: rtl/psr_shift_top.sv
module psr_shift_top
    import psr_pkg::*;
#(
    parameter int WIDTH = PSR_DEF_WIDTH,
    parameter int TAPS  = PSR_DEF_TAPS
) (
    input  logic             clk_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [TAPS-1:0]  tap_o,
    output logic             ser_o
);
    localparam int TAP_BASE = WIDTH - TAPS;
    localparam int LAST     = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] chain;
    } shift_t;

    shift_t           state_d;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] set_w;
    logic [WIDTH-1:0] clr_w;

    psr_load_decode #(.WIDTH(WIDTH)) u_dec (
        .load_i (load_i),
        .par_i  (par_i),
        .set_o  (set_w),
        .clr_o  (clr_w)
    );

    always_comb begin
        state_d.chain = {stage_q[WIDTH-2:0], ser_i};
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_stage
        psr_stage u_stage (
            .clk_i (clk_i),
            .set_i (set_w[k]),
            .clr_i (clr_w[k]),
            .d_i   (state_d.chain[k]),
            .q_o   (stage_q[k])
        );
    end

    assign tap_o = stage_q[LAST:TAP_BASE];
    assign ser_o = stage_q[LAST];

    // Assertion support: high only when the previous clock edge was itself a shift edge
    logic shift_prev_q;
    always_ff @(posedge clk_i or posedge load_i) begin
        if (load_i) shift_prev_q <= 1'b0;
        else        shift_prev_q <= 1'b1;
    end

    // R3: serial input lands in the first stage
    a_r3_serial_entry: assert property (@(posedge clk_i) disable iff (load_i)
        shift_prev_q |-> stage_q[0] == $past(ser_i))
        else $error("stage 0 did not take serial input");

    // R3: every later stage takes its neighbour
    for (genvar k = 1; k < WIDTH; k++) begin : g_chk
        a_r3_neighbour_move: assert property (@(posedge clk_i) disable iff (load_i)
            shift_prev_q |-> stage_q[k] == $past(stage_q[k-1]))
            else $error("stage %0d did not take its neighbour", k);
    end
endmodule

// File: tb/tb_psr_shift_top.sv
`timescale 1ns/1ps
module tb_psr_shift_top;
    localparam int W = 8;

    logic         clk_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic         ser_i = 1'b0;
    logic [2:0]   tap_o;
    logic         ser_o;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] model;
    bit done = 0;

    psr_shift_top dut (
        .clk_i (clk_i), .load_i (load_i), .par_i (par_i),
        .ser_i (ser_i), .tap_o (tap_o), .ser_o (ser_o)
    );

    task automatic chk(input string tag, input logic [2:0] exp_tap, input logic exp_ser);
        total++;
        if (tap_o !== exp_tap || ser_o !== exp_ser) begin
            bad++;
            $display("FAIL %s tap=%b ser=%b expected tap=%b ser=%b",
                     tag, tap_o, ser_o, exp_tap, exp_ser);
        end
    endtask

    // one 50 MHz cycle: rise at +10, fall at +20, outputs sampled after the fall
    task automatic tick();
        #10 clk_i = 1'b1;
        #10 clk_i = 1'b0;
    endtask

    task automatic shift_bit(input logic b);
        ser_i = b;
        tick();
        if (!load_i) model = {model[W-2:0], b};
    endtask

    task automatic do_load(input logic [W-1:0] v);
        par_i  = v;
        #3 load_i = 1'b1;
        #2;
        model = v;
    endtask

    task automatic release_load();
        #3 load_i = 1'b0;
        #2;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #5;
        // initial load acts as reset
        do_load(8'h00);
        chk("R2 load zero", 3'b000, 1'b0);
        release_load();
        chk("R6 hold after release", 3'b000, 1'b0);

        // exhaustive over every parallel pattern
        for (int p = 0; p < 256; p++) begin
            do_load(p[W-1:0]);
            chk("R8 R7 tap after load", model[7:5], model[7]);
            release_load();
            for (int s = 1; s <= W; s++) begin
                shift_bit(p[(s+2)%W] ^ s[0]);
                if (s == 7) chk("R1 bit0 reaches end", model[7:5], p[0]);
                else        chk("R3 R4 shift", model[7:5], model[7]);
            end
        end

        // par change while load held high
        do_load(8'h1F);
        chk("R2 load 1F", 3'b000, 1'b0);
        par_i = 8'hE0; #2;
        chk("R2 follow without clock", 3'b111, 1'b1);
        par_i = 8'h40; #2;
        chk("R2 follow second change", 3'b010, 1'b0);
        model = 8'h40;

        // clock edges during load ignored
        ser_i = 1'b1; tick(); tick();
        chk("R5 edges ignored during load", 3'b010, 1'b0);
        release_load();
        chk("R5 no shift at release", 3'b010, 1'b0);
        shift_bit(1'b0);
        chk("R5 first edge shifts", 3'b100, 1'b1);

        // load in the middle of a shift sequence
        do_load(8'hA7);
        release_load();
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        chk("R3 three shifts", model[7:5], model[7]);
        do_load(8'h5C);
        chk("R2 mid-sequence load", 3'b010, 1'b0);
        release_load();
        shift_bit(1'b1);
        chk("R3 shift after mid load", 3'b101, 1'b1);

        // static hold with clock stopped
        #100000;
        chk("R6 hold with clock stopped", model[7:5], model[7]);
        shift_bit(1'b0);
        chk("R6 shift resumes", model[7:5], model[7]);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule